// File: doc/BRIEF.md
# Nibble Register Execute Stage

This block is the execute stage of a small 4-bit processor. It handles only the instructions that move data between registers. It holds sixteen 4-bit general registers and three status flags: carry C, zero Z and signed overflow V. A 12-bit instruction word arrives together with a valid strobe. In the same cycle the stage decodes the word, reads its operands and computes the result. On the next rising clock edge it writes the result and the new flags together, so one instruction can be issued on every cycle.

The top 4-bit field of the instruction selects an operation on two registers, X and Y. When that field is zero, the upper eight bits together form an extended code that acts on the single register Y. Every other code is a no-operation. A combinational debug port returns the contents of any register. There is no program counter, no memory access and no immediate operand here; the surrounding pipeline provides those.

The control is a single-cycle decode followed by writeback, with no internal states between instructions.

Top module: `nib_exec_unit`

## Requirements
- R1: After reset all sixteen registers read 0 and C, Z and V are 0.
- R2: While the valid strobe is low, no register and no flag changes, whatever the instruction bits.
- R3: Field layout: bits 11..8 are the primary code, bits 7..4 the X index and bits 3..0 the Y index. Primary code 0x1 adds: X gets X+Y mod 16, C is the carry out of bit 3, V is signed overflow, Z is set when the result is 0, and Y keeps its value.
- R4: Code 0x2 adds with carry: X gets X+Y+C, with C, V and Z formed as in R3.
- R5: Code 0x3 subtracts: X gets X−Y mod 16. C is 1 when no borrow occurs (X ≥ Y). V is signed overflow and Z is set on a zero result.
- R6: Code 0x4 subtracts with borrow: X gets X−Y−(1−C). C is 1 when that difference is not negative. V and Z are formed as in R5.
- R7: Codes 0x5, 0x6 and 0x7 write X OR Y, X AND Y and X XOR Y into X. They update Z and leave C and V unchanged.
- R8: Code 0x8 copies Y into X and leaves all three flags unchanged.
- R9: When bits 11..8 are 0, bits 11..4 form an extended code. Code 0x02 writes Y+1 mod 16 into Y and code 0x03 writes Y−1 mod 16 into Y. Both update Z and keep C and V.
- R10: Extended code 0x0D rotates Y right through carry: Y gets {C, Y[3:1]}, C gets the old Y[0], Z is updated and V is kept.
- R11: Primary codes 0x9 to 0xF and the extended codes other than 0x02, 0x03 and 0x0D change no register and no flag.
- R12: The debug port returns, in the same cycle, the register selected by the debug index.
- R13: Instructions issued on consecutive cycles each see the results of the one before, including cases where X and Y name the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 12 | Instruction word |
| instr_valid_i | input | 1 | Execute instr_i on this edge |
| dbg_idx_i | input | 4 | Debug register index |
| dbg_data_o | output | 4 | Contents of the selected register |
| flag_c_o | output | 1 | Carry flag (no-borrow for subtraction) |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Signed overflow flag |

## Verification
The assertions check, on every cycle, the rules about holding state: an idle strobe writes nothing and leaves the flags alone, a register copy leaves the flags alone, the logic operations keep C and V, and unlisted codes never write. They also check that Z always follows the value just written back. Whether the written values and the C and V flags are arithmetically correct can only be shown by the bench's scenarios. The bench sweeps all 16×16 operand pairs with both carry-in values for every operation and compares the result with an independent model, which also covers the rotate's carry path and the chained back-to-back issue.

// File: rtl/nib_exec_pkg.sv
package nib_exec_pkg;

    localparam int FIELD_W = 4;
    localparam int INSTR_W = 3 * FIELD_W;

    // primary codes, bits 11..8
    localparam logic [FIELD_W-1:0] PRI_EXT = 4'h0;
    localparam logic [FIELD_W-1:0] PRI_ADD = 4'h1;
    localparam logic [FIELD_W-1:0] PRI_ADC = 4'h2;
    localparam logic [FIELD_W-1:0] PRI_SUB = 4'h3;
    localparam logic [FIELD_W-1:0] PRI_SBB = 4'h4;
    localparam logic [FIELD_W-1:0] PRI_OR  = 4'h5;
    localparam logic [FIELD_W-1:0] PRI_AND = 4'h6;
    localparam logic [FIELD_W-1:0] PRI_XOR = 4'h7;
    localparam logic [FIELD_W-1:0] PRI_MOV = 4'h8;

    // extended codes, bits 7..4 when the primary field is zero
    localparam logic [FIELD_W-1:0] EXT_INC = 4'h2;
    localparam logic [FIELD_W-1:0] EXT_DEC = 4'h3;
    localparam logic [FIELD_W-1:0] EXT_RRC = 4'hD;

    typedef enum logic [3:0] {
        OP_NOP, OP_ADD, OP_ADC, OP_SUB, OP_SBB,
        OP_OR,  OP_AND, OP_XOR, OP_MOV,
        OP_INC, OP_DEC, OP_RRC
    } alu_op_e;

endpackage

// File: rtl/nib_decode.sv
module nib_decode
    import nib_exec_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               valid_i,
    output alu_op_e            op_o,
    output logic [FIELD_W-1:0] a_idx_o,
    output logic [FIELD_W-1:0] b_idx_o,
    output logic [FIELD_W-1:0] dst_idx_o,
    output logic               we_o,
    output logic               upd_c_o,
    output logic               upd_z_o,
    output logic               upd_v_o
);

    logic [FIELD_W-1:0] f_pri, f_x, f_y;
    alu_op_e            op_raw;

    assign f_pri = instr_i[3*FIELD_W-1:2*FIELD_W];
    assign f_x   = instr_i[2*FIELD_W-1:FIELD_W];
    assign f_y   = instr_i[FIELD_W-1:0];

    always_comb begin
        op_raw    = OP_NOP;
        a_idx_o   = f_x;
        b_idx_o   = f_y;
        dst_idx_o = f_x;
        unique case (f_pri)
            PRI_EXT: begin
                a_idx_o   = f_y;
                dst_idx_o = f_y;
                unique case (f_x)
                    EXT_INC: op_raw = OP_INC;
                    EXT_DEC: op_raw = OP_DEC;
                    EXT_RRC: op_raw = OP_RRC;
                    default: op_raw = OP_NOP;
                endcase
            end
            PRI_ADD: op_raw = OP_ADD;
            PRI_ADC: op_raw = OP_ADC;
            PRI_SUB: op_raw = OP_SUB;
            PRI_SBB: op_raw = OP_SBB;
            PRI_OR:  op_raw = OP_OR;
            PRI_AND: op_raw = OP_AND;
            PRI_XOR: op_raw = OP_XOR;
            PRI_MOV: op_raw = OP_MOV;
            default: op_raw = OP_NOP;
        endcase
    end

    assign op_o = valid_i ? op_raw : OP_NOP;

    always_comb begin
        we_o    = 1'b1;
        upd_c_o = 1'b0;
        upd_z_o = 1'b0;
        upd_v_o = 1'b0;
        unique case (op_o)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
                upd_c_o = 1'b1;
                upd_z_o = 1'b1;
                upd_v_o = 1'b1;
            end
            OP_OR, OP_AND, OP_XOR, OP_INC, OP_DEC: upd_z_o = 1'b1;
            OP_RRC: begin
                upd_c_o = 1'b1;
                upd_z_o = 1'b1;
            end
            OP_MOV:  we_o = 1'b1;
            default: we_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/nib_alu.sv
module nib_alu
    import nib_exec_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              c_i,
    output logic [DATA_W-1:0] res_o,
    output logic              c_o,
    output logic              v_o,
    output logic              z_o
);

    logic [DATA_W-1:0] add_b;
    logic              add_cin;
    logic [DATA_W:0]   chain;
    logic [DATA_W-1:0] sum;

    // operand conditioning for the shared ripple adder
    always_comb begin
        add_b   = b_i;
        add_cin = 1'b0;
        unique case (op_i)
            OP_ADC:  add_cin = c_i;
            OP_SUB:  begin add_b = ~b_i; add_cin = 1'b1; end
            OP_SBB:  begin add_b = ~b_i; add_cin = c_i;  end
            OP_INC:  begin add_b = '0;   add_cin = 1'b1; end
            OP_DEC:  begin add_b = '1;   add_cin = 1'b0; end
            default: ;
        endcase
    end

    assign chain[0] = add_cin;

    for (genvar i = 0; i < DATA_W; i++) begin : g_fa
        assign sum[i]     = a_i[i] ^ add_b[i] ^ chain[i];
        assign chain[i+1] = (a_i[i] & add_b[i]) | (chain[i] & (a_i[i] ^ add_b[i]));
    end

    always_comb begin
        res_o = sum;
        c_o   = chain[DATA_W];
        v_o   = chain[DATA_W] ^ chain[DATA_W-1];
        unique case (op_i)
            OP_OR:  res_o = a_i | b_i;
            OP_AND: res_o = a_i & b_i;
            OP_XOR: res_o = a_i ^ b_i;
            OP_MOV: res_o = b_i;
            OP_RRC: begin
                res_o = {c_i, a_i[DATA_W-1:1]};
                c_o   = a_i[0];
            end
            default: ;
        endcase
    end

    assign z_o = (res_o == '0);

endmodule

// File: rtl/nib_regfile.sv
module nib_regfile #(
    parameter  int DATA_W   = 4,
    parameter  int NUM_REGS = 16,
    localparam int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  raddr_a_i,
    output logic [DATA_W-1:0] rdata_a_o,
    input  logic [IDX_W-1:0]  raddr_b_i,
    output logic [DATA_W-1:0] rdata_b_o,
    input  logic [IDX_W-1:0]  raddr_d_i,
    output logic [DATA_W-1:0] rdata_d_o
);

    logic [DATA_W-1:0] regs [NUM_REGS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
        end else if (we_i) begin
            regs[waddr_i] <= wdata_i;
        end
    end

    assign rdata_a_o = regs[raddr_a_i];
    assign rdata_b_o = regs[raddr_b_i];
    assign rdata_d_o = regs[raddr_d_i];

endmodule

// File: rtl/nib_exec_unit.sv
module nib_exec_unit
    import nib_exec_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               instr_valid_i,
    input  logic [FIELD_W-1:0] dbg_idx_i,
    output logic [DATA_W-1:0]  dbg_data_o,
    output logic               flag_c_o,
    output logic               flag_z_o,
    output logic               flag_v_o
);

    localparam int NUM_REGS = 1 << FIELD_W;

    alu_op_e            dec_op;
    logic [FIELD_W-1:0] a_idx, b_idx, dst_idx;
    logic               rf_we, dec_upd_c, dec_upd_z, dec_upd_v;
    logic [DATA_W-1:0]  rd_a, rd_b, alu_res;
    logic               alu_c, alu_v, alu_z;

    nib_decode u_decode (
        .instr_i   (instr_i),
        .valid_i   (instr_valid_i),
        .op_o      (dec_op),
        .a_idx_o   (a_idx),
        .b_idx_o   (b_idx),
        .dst_idx_o (dst_idx),
        .we_o      (rf_we),
        .upd_c_o   (dec_upd_c),
        .upd_z_o   (dec_upd_z),
        .upd_v_o   (dec_upd_v)
    );

    nib_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (rf_we),
        .waddr_i   (dst_idx),
        .wdata_i   (alu_res),
        .raddr_a_i (a_idx),
        .rdata_a_o (rd_a),
        .raddr_b_i (b_idx),
        .rdata_b_o (rd_b),
        .raddr_d_i (dbg_idx_i),
        .rdata_d_o (dbg_data_o)
    );

    nib_alu #(.DATA_W(DATA_W)) u_alu (
        .op_i  (dec_op),
        .a_i   (rd_a),
        .b_i   (rd_b),
        .c_i   (flag_c_o),
        .res_o (alu_res),
        .c_o   (alu_c),
        .v_o   (alu_v),
        .z_o   (alu_z)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_c_o <= 1'b0;
            flag_z_o <= 1'b0;
            flag_v_o <= 1'b0;
        end else begin
            if (dec_upd_c) flag_c_o <= alu_c;
            if (dec_upd_z) flag_z_o <= alu_z;
            if (dec_upd_v) flag_v_o <= alu_v;
        end
    end

endmodule

// File: rtl/nib_exec_unit_chk.sv
module nib_exec_unit_chk
    import nib_exec_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [INSTR_W-1:0] instr_i,
    input logic               instr_valid_i,
    input logic               flag_c_o,
    input logic               flag_z_o,
    input logic               flag_v_o,
    input logic               rf_we,
    input logic               dec_upd_z,
    input logic [DATA_W-1:0]  alu_res
);

    logic [3:0] c_pri, c_ext;
    logic       is_logic, is_unlisted;

    assign c_pri       = instr_i[11:8];
    assign c_ext       = instr_i[7:4];
    assign is_logic    = (c_pri == 4'h5) || (c_pri == 4'h6) || (c_pri == 4'h7);
    assign is_unlisted = (c_pri > 4'h8) ||
                         ((c_pri == 4'h0) && (c_ext != 4'h2) && (c_ext != 4'h3) && (c_ext != 4'hD));

    p_idle_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid_i |=> ($stable(flag_c_o) && $stable(flag_z_o) && $stable(flag_v_o)));

    p_idle_nowrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid_i |-> !rf_we);

    p_zero_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_upd_z |=> (flag_z_o == ($past(alu_res) == '0)));

    p_logic_keep_cv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid_i && is_logic) |=> ($stable(flag_c_o) && $stable(flag_v_o)));

    p_copy_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid_i && c_pri == 4'h8) |=> ($stable(flag_c_o) && $stable(flag_z_o) && $stable(flag_v_o)));

    p_unlisted_nowrite_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid_i && is_unlisted) |-> !rf_we);

    p_unlisted_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid_i && is_unlisted) |=> ($stable(flag_c_o) && $stable(flag_z_o) && $stable(flag_v_o)));

endmodule

bind nib_exec_unit nib_exec_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_i       (instr_i),
    .instr_valid_i (instr_valid_i),
    .flag_c_o      (flag_c_o),
    .flag_z_o      (flag_z_o),
    .flag_v_o      (flag_v_o),
    .rf_we         (rf_we),
    .dec_upd_z     (dec_upd_z),
    .alu_res       (alu_res)
);

// File: tb/nib_exec_unit_bench.sv
module nib_exec_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] instr_i;
    logic        instr_valid_i;
    logic [3:0]  dbg_idx_i;
    logic [3:0]  dbg_data_o;
    logic        flag_c_o, flag_z_o, flag_v_o;

    always #5 clk = ~clk;

    nib_exec_unit u_nib_exec_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_i       (instr_i),
        .instr_valid_i (instr_valid_i),
        .dbg_idx_i     (dbg_idx_i),
        .dbg_data_o    (dbg_data_o),
        .flag_c_o      (flag_c_o),
        .flag_z_o      (flag_z_o),
        .flag_v_o      (flag_v_o)
    );

    int n_run = 0, n_fail = 0, cyc = 0;
    bit done = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // reference state
    int m_reg [16];
    int m_c, m_z, m_v;

    typedef struct {
        int    due;
        int    ia, va, ib, vb;
        int    c, z, v;
        string req;
    } exp_t;
    exp_t sb[$];

    task automatic check(string req, string what, int act, int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int sg(int n);
        return (n > 7) ? n - 16 : n;
    endfunction

    function automatic int ovf(int s);
        return (s > 7 || s < -8) ? 1 : 0;
    endfunction

    function automatic string model_step(logic [11:0] ins);
        int    xi = int'(ins[7:4]);
        int    yi = int'(ins[3:0]);
        int    x = m_reg[xi];
        int    y = m_reg[yi];
        int    d, bw;
        string req = "R11";
        case (ins[11:8])
            4'h1: begin d = x + y; m_c = (d > 15); m_v = ovf(sg(x) + sg(y)); req = "R3"; end
            4'h2: begin d = x + y + m_c; m_v = ovf(sg(x) + sg(y) + m_c); m_c = (d > 15); req = "R4"; end
            4'h3: begin d = x - y; m_c = (d >= 0); m_v = ovf(sg(x) - sg(y)); req = "R5"; end
            4'h4: begin bw = 1 - m_c; d = x - y - bw; m_c = (d >= 0); m_v = ovf(sg(x) - sg(y) - bw); req = "R6"; end
            4'h5: begin d = x | y; req = "R7"; end
            4'h6: begin d = x & y; req = "R7"; end
            4'h7: begin d = x ^ y; req = "R7"; end
            4'h8: begin m_reg[xi] = y; return "R8"; end
            4'h0: begin
                case (ins[7:4])
                    4'h2: begin d = y + 1; req = "R9"; end
                    4'h3: begin d = y - 1; req = "R9"; end
                    4'hD: begin d = (m_c << 3) | (y >> 1); m_c = y & 1; req = "R10"; end
                    default: return "R11";
                endcase
                m_reg[yi] = d & 15;
                m_z = ((d & 15) == 0);
                return req;
            end
            default: return "R11";
        endcase
        m_reg[xi] = d & 15;
        m_z = ((d & 15) == 0);
        return req;
    endfunction

    function automatic exp_t snap(int ia, int ib, string req);
        exp_t e;
        e.due = cyc + 1;
        e.ia = ia; e.va = m_reg[ia];
        e.ib = ib; e.vb = m_reg[ib];
        e.c = m_c; e.z = m_z; e.v = m_v;
        e.req = req;
        return e;
    endfunction

    // driver: one valid instruction per cycle
    task automatic issue(logic [11:0] ins);
        string req;
        @(posedge clk);
        #2;
        instr_i       = ins;
        instr_valid_i = 1'b1;
        req = model_step(ins);
        sb.push_back(snap(int'(ins[7:4]), int'(ins[3:0]), req));
    endtask

    // R2: strobe low with live-looking instruction bits
    task automatic idle(logic [11:0] ins);
        @(posedge clk);
        #2;
        instr_i       = ins;
        instr_valid_i = 1'b0;
        sb.push_back(snap(int'(ins[7:4]), int'(ins[3:0]), "R2"));
    endtask

    task automatic set_carry(int c);
        issue({4'h8, 4'h0, 4'hF});                  // r0 <- 15
        issue({4'h1, 4'h0, (c != 0) ? 4'hF : 4'h2}); // 15+15 carries, 15+2 does too
        if (c == 0) issue({4'h3, 4'h0, 4'h0});      // r0-r0: no borrow -> C=1
        if (c == 0) issue({4'h4, 4'h0, 4'hF});      // 0-15-0 borrows -> C=0
    endtask

    task automatic load(logic [3:0] dst, int val);
        if (val >= 2) issue({4'h8, dst, 4'(val)});
        else begin
            issue({4'h7, dst, dst});
            if (val == 1) issue({8'h02, dst});
        end
    endtask

    // monitor: compare each item after its execute edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                e = sb.pop_front();
                dbg_idx_i = 4'(e.ia);
                #1;
                check(e.req, $sformatf("R12 reg%0d", e.ia), int'(dbg_data_o), e.va);
                dbg_idx_i = 4'(e.ib);
                #1;
                check(e.req, $sformatf("R12 reg%0d", e.ib), int'(dbg_data_o), e.vb);
                check(e.req, "flag C", int'(flag_c_o), e.c);
                check(e.req, "flag Z", int'(flag_z_o), e.z);
                check(e.req, "flag V", int'(flag_v_o), e.v);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R13 watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; instr_valid_i = 1'b0; instr_i = '0; dbg_idx_i = '0;
        for (int i = 0; i < 16; i++) m_reg[i] = 0;
        m_c = 0; m_z = 0; m_v = 0;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        // R1: reset state seen through the debug port
        for (int i = 0; i < 16; i++) begin
            dbg_idx_i = 4'(i);
            #1;
            check("R1", $sformatf("reg%0d", i), int'(dbg_data_o), 0);
        end
        check("R1", "flag C", int'(flag_c_o), 0);
        check("R1", "flag Z", int'(flag_z_o), 0);
        check("R1", "flag V", int'(flag_v_o), 0);

        // constants: reg k holds k for k = 2..15 (R9 increments)
        for (int k = 2; k < 16; k++)
            for (int n = 0; n < k; n++) issue({8'h02, 4'(k)});

        // R2: strobe low, several patterns
        idle({4'h1, 4'h4, 4'h5});
        idle({8'h0D, 4'h7});
        idle({4'h8, 4'h3, 4'hF});

        // R3..R8, R13: all pairs, both carry-ins, issued back to back
        for (int op = 1; op <= 8; op++)
            for (int c = 0; c < 2; c++)
                for (int x = 0; x < 16; x++)
                    for (int y = 0; y < 16; y++) begin
                        set_carry(c);
                        load(4'h1, y);
                        load(4'h0, x);
                        issue({4'(op), 4'h0, 4'h1});
                    end

        // R9, R10: single-register forms, every value and carry-in
        for (int e = 0; e < 3; e++)
            for (int c = 0; c < 2; c++)
                for (int y = 0; y < 16; y++) begin
                    set_carry(c);
                    load(4'h1, y);
                    issue({4'h0, (e == 0) ? 4'h2 : (e == 1) ? 4'h3 : 4'hD, 4'h1});
                end

        // R13: X and Y name the same register
        load(4'h0, 9);
        issue({4'h1, 4'h0, 4'h0});
        issue({4'h4, 4'h0, 4'h0});
        issue({4'h8, 4'h1, 4'h0});

        // R11: unlisted primary and extended codes
        set_carry(1);
        for (int p = 9; p < 16; p++) issue({4'(p), 4'h4, 4'h5});
        for (int x = 0; x < 16; x++)
            if (x != 2 && x != 3 && x != 13) issue({4'h0, 4'(x), 4'h6});

        idle(12'h000);
        repeat (4) @(posedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule